// File: doc/BRIEF.md
# Prescaled PWM backlight generator

This block produces a single pulse-width-modulated output for dimming a display backlight. A host writes its settings through a byte-wide register port. The settings are an 8-bit prescaler, a 16-bit period scale, a 16-bit duty value, a control byte and a pin-select byte. The block counts its clock, which serves as the reference clock. Each PWM period lasts prescaler times scale plus one cycles. The output is active for the first prescaler times duty cycles of the period.

Writes to the scale, duty and prescaler registers go to shadow copies. The counters take up the shadow values only at the end of a period, so a period never runs with a half-written value. The pad is shared with general-purpose output use. A 2-bit field in the pin-select byte decides whether the pad carries the PWM waveform or the plain output bit `gpio_i`.

Top module: `bl_pwm_gen`

## Requirements
- R1: While enabled, the output repeats with a period of N = P*S + 1 clock cycles. P is the effective prescaler and S is the scale. The first period starts in the cycle after the enable bit is written to 1.
- R2: For 0 < duty < S, the output is active in period cycles t = 0 .. P*duty-1 and inactive for the rest of the period.
- R3: A nonzero duty that is greater than or equal to S gives a constantly active output. A duty of 0 gives a constantly inactive output, whatever the scale.
- R4: A prescaler value of 0 behaves exactly like a prescaler of 1.
- R5: The register map is as follows:
  - 0xA0: prescaler.
  - 0xA1 and 0xA2: scale, low byte then high byte.
  - 0xA3 and 0xA4: duty, low byte then high byte.
  - 0xA5: control, with bit 1 as enable and bit 0 as invert.
  - 0xA8: pin select.

  Every one of these registers reads back the full byte last written to it.
- R6: Reads from any address outside those seven return 0, and writes to such addresses have no effect.
- R7: A change to scale, duty or prescaler made while the generator is enabled takes effect at the start of the next period, not in the current one.
- R8: While enable is 0, the output sits at its inactive level and the counters are held at the start of a period.
- R9: The invert bit sets the polarity. With invert 0, active is 1 and inactive is 0. With invert 1, both levels are swapped.
- R10: The pad carries the PWM output only when bits [7:6] of the pin-select register equal 2'b10. Any other value puts `gpio_i` on the pad.
- R11: After reset, all registers read 0 and the pad follows `gpio_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; all counting is in its cycles |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| gpio_i | input | 1 | Plain output bit used when the PWM is not selected |
| pad_o | output | 1 | Pad drive |

## Verification
The sweep covers prescalers 0 to 3 across several small scales, with every duty from 0 to one past the scale, under both polarities. This exposes four kinds of fault:
- An off-by-one period, such as dropping the extra cycle, shows as a pattern that drifts against the bench's expected period.
- A wrong comparison at duty equal to scale shows as a short low pulse.
- A prescaler of 0 left untreated shows as a hang or a period of the wrong length.
- A swapped byte pair shows in the 16-bit scale case with a nonzero high byte.

A duty change written in the middle of a period must leave that period untouched. A design without shadowing alters the waveform at once. Pin-select values other than the special code must route `gpio_i`. Out-of-range reads, and writes to unused addresses, must return zero.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  localparam int PRE_W    = 8;
  localparam int SCALE_W  = 16;
  localparam int NUM_BANK = 6;
  localparam int OFS_PRE  = 0;
  localparam int OFS_SLO  = 1;
  localparam int OFS_SHI  = 2;
  localparam int OFS_DLO  = 3;
  localparam int OFS_DHI  = 4;
  localparam int OFS_CTRL = 5;
  localparam int CTRL_EN  = 1;
  localparam int CTRL_INV = 0;

  typedef struct packed {
    logic [PRE_W-1:0]   pre;
    logic [SCALE_W-1:0] scale;
    logic [SCALE_W-1:0] duty;
    logic               en;
    logic               inv;
  } cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'hA0,
  parameter logic [7:0] MUX_ADDR  = 8'hA8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output cfg_t       cfg_o,
  output logic [7:0] mux_o
);
  logic [7:0] bank_q [NUM_BANK];
  logic [7:0] mux_q;

  for (genvar i = 0; i < NUM_BANK; i++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    bank_q[i] <= '0;
      else if (we_i && addr_i == BASE_ADDR + 8'(i))   bank_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mux_q <= '0;
    else if (we_i && addr_i == MUX_ADDR)  mux_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_BANK; i++)
      if (addr_i == BASE_ADDR + 8'(i)) rdata_o = bank_q[i];
    if (addr_i == MUX_ADDR) rdata_o = mux_q;
  end

  assign cfg_o.pre   = bank_q[OFS_PRE];
  assign cfg_o.scale = {bank_q[OFS_SHI], bank_q[OFS_SLO]};
  assign cfg_o.duty  = {bank_q[OFS_DHI], bank_q[OFS_DLO]};
  assign cfg_o.en    = bank_q[OFS_CTRL][CTRL_EN];
  assign cfg_o.inv   = bank_q[OFS_CTRL][CTRL_INV];
  assign mux_o       = mux_q;
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cfg_t               cfg_i,
  output logic               pwm_o,
  output logic [SCALE_W-1:0] step_o,
  output logic [SCALE_W-1:0] act_scale_o,
  output logic [SCALE_W-1:0] act_duty_o
);
  logic [PRE_W-1:0]   act_pre_q, pre_cnt_q, pre_last;
  logic [SCALE_W-1:0] act_scale_q, act_duty_q, step_q;
  logic               wrap, active;

  // prescaler 0 counts as 1
  assign pre_last = (act_pre_q == '0) ? '0 : act_pre_q - 1'b1;
  assign wrap     = (step_q == act_scale_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pre_q   <= '0;
      act_scale_q <= '0;
      act_duty_q  <= '0;
      step_q      <= '0;
      pre_cnt_q   <= '0;
    end else if (!cfg_i.en || wrap) begin
      act_pre_q   <= cfg_i.pre;
      act_scale_q <= cfg_i.scale;
      act_duty_q  <= cfg_i.duty;
      step_q      <= '0;
      pre_cnt_q   <= '0;
    end else if (pre_cnt_q == pre_last) begin
      pre_cnt_q   <= '0;
      step_q      <= step_q + 1'b1;
    end else begin
      pre_cnt_q   <= pre_cnt_q + 1'b1;
    end
  end

  assign active = (act_duty_q != '0) &&
                  ((act_duty_q >= act_scale_q) || (step_q < act_duty_q));
  assign pwm_o  = cfg_i.en ? (active ^ cfg_i.inv) : cfg_i.inv;

  assign step_o      = step_q;
  assign act_scale_o = act_scale_q;
  assign act_duty_o  = act_duty_q;
endmodule

// File: rtl/bl_pwm_pinmux.sv
module bl_pwm_pinmux #(
  parameter int         MUX_LSB = 6,
  parameter logic [1:0] MUX_FN  = 2'b10
) (
  input  logic [7:0] mux_i,
  input  logic       pwm_i,
  input  logic       gpio_i,
  output logic       pad_o
);
  assign pad_o = (mux_i[MUX_LSB +: 2] == MUX_FN) ? pwm_i : gpio_i;
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pwm_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'hA0,
  parameter logic [7:0] MUX_ADDR  = 8'hA8,
  parameter int         MUX_LSB   = 6,
  parameter logic [1:0] MUX_FN    = 2'b10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       gpio_i,
  output logic       pad_o
);
  cfg_t               cfg;
  logic [7:0]         mux_sel;
  logic               pwm;
  logic [SCALE_W-1:0] step_cnt, act_scale, act_duty;

  bl_pwm_regs #(.BASE_ADDR(BASE_ADDR), .MUX_ADDR(MUX_ADDR)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cfg_o(cfg), .mux_o(mux_sel)
  );

  bl_pwm_core i_core (
    .clk_i, .rst_ni, .cfg_i(cfg), .pwm_o(pwm),
    .step_o(step_cnt), .act_scale_o(act_scale), .act_duty_o(act_duty)
  );

  bl_pwm_pinmux #(.MUX_LSB(MUX_LSB), .MUX_FN(MUX_FN)) i_pinmux (
    .mux_i(mux_sel), .pwm_i(pwm), .gpio_i, .pad_o
  );
endmodule

// File: rtl/bl_pwm_chk.sv
module bl_pwm_chk
  import bl_pwm_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'hA0,
  parameter logic [7:0] MUX_ADDR  = 8'hA8,
  parameter int         MUX_LSB   = 6,
  parameter logic [1:0] MUX_FN    = 2'b10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [7:0]         addr_i,
  input logic [7:0]         wdata_i,
  input logic [7:0]         rdata_o,
  input logic               gpio_i,
  input logic               pad_o,
  input cfg_t               cfg,
  input logic [7:0]         mux_sel,
  input logic [SCALE_W-1:0] step_cnt,
  input logic [SCALE_W-1:0] act_scale,
  input logic [SCALE_W-1:0] act_duty
);
  logic fn_sel, in_map;
  assign fn_sel = (mux_sel[MUX_LSB +: 2] == MUX_FN);
  assign in_map = ((addr_i >= BASE_ADDR) && (addr_i < BASE_ADDR + 8'(NUM_BANK))) ||
                  (addr_i == MUX_ADDR);

  assert_mux_gpio_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fn_sel |-> pad_o == gpio_i);

  assert_idle_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_sel && !cfg.en) |-> pad_o == cfg.inv);

  assert_oob_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_map |-> rdata_o == 8'h00);

  assert_wr_readback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == BASE_ADDR) |=> cfg.pre == $past(wdata_i));

  assert_step_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.en |-> step_cnt <= act_scale);

  assert_shadow_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.en && $past(cfg.en) && ($past(step_cnt) != $past(act_scale)))
      |-> ($stable(act_duty) && $stable(act_scale)));

  assert_idle_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.en |=> (act_duty == $past(cfg.duty) && act_scale == $past(cfg.scale)));

  assert_full_duty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn_sel && cfg.en && act_duty != '0 && act_duty >= act_scale) |-> pad_o == !cfg.inv);
endmodule

bind bl_pwm_gen bl_pwm_chk #(
  .BASE_ADDR(BASE_ADDR), .MUX_ADDR(MUX_ADDR), .MUX_LSB(MUX_LSB), .MUX_FN(MUX_FN)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .gpio_i(gpio_i), .pad_o(pad_o), .cfg(cfg), .mux_sel(mux_sel),
  .step_cnt(step_cnt), .act_scale(act_scale), .act_duty(act_duty)
);

// File: tb/test_bl_pwm_gen.sv
module test_bl_pwm_gen;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       gpio_i = 1'b0;
  logic       pad_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bl_pwm_gen i_bl_pwm_gen (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .gpio_i, .pad_o
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr_i = a;
    #1;
    chk({8'h00, rdata_o}, {8'h00, exp}, tag);
  endtask

  function automatic bit exp_out(int pe, int sc, int du, bit inv, int t);
    int  n;
    bit  a;
    n = pe * sc + 1;
    if (du == 0)        a = 1'b0;
    else if (du >= sc)  a = 1'b1;
    else                a = ((t % n) < pe * du);
    return a ^ inv;
  endfunction

  task automatic run_cfg(input int pre, input int sc, input int du, input bit inv,
                         input int ncyc, input string tag);
    int pe;
    wr(8'hA5, {6'b0, 1'b0, inv});
    wr(8'hA0, 8'(pre));
    wr(8'hA1, sc[7:0]);
    wr(8'hA2, sc[15:8]);
    wr(8'hA3, du[7:0]);
    wr(8'hA4, du[15:8]);
    chk({15'b0, pad_o}, {15'b0, inv}, "R8 idle level");
    wr(8'hA5, {6'b0, 1'b1, inv});
    pe = (pre == 0) ? 1 : pre;
    for (int t = 0; t < ncyc; t++) begin
      chk({15'b0, pad_o}, {15'b0, exp_out(pe, sc, du, inv, t)}, tag);
      @(negedge clk_i);
    end
  endtask

  initial begin
    int scales [5] = '{0, 1, 2, 3, 5};
    repeat (3) @(negedge clk_i);
    // R11 reset state
    for (int a = 8'hA0; a <= 8'hA8; a++) rd(8'(a), 8'h00, "R11 reset read");
    gpio_i = 1'b1; #1; chk({15'b0, pad_o}, 16'd1, "R11 pad follows gpio");
    gpio_i = 1'b0; #1; chk({15'b0, pad_o}, 16'd0, "R11 pad follows gpio");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 and R6 register map
    wr(8'hA0, 8'h5A); wr(8'hA1, 8'h11); wr(8'hA2, 8'h22);
    wr(8'hA3, 8'h33); wr(8'hA4, 8'h44); wr(8'hA5, 8'hFC); wr(8'hA8, 8'h3C);
    wr(8'hA6, 8'hEE); wr(8'h00, 8'h77);
    rd(8'hA0, 8'h5A, "R5 prescaler"); rd(8'hA1, 8'h11, "R5 scale lo");
    rd(8'hA2, 8'h22, "R5 scale hi");  rd(8'hA3, 8'h33, "R5 duty lo");
    rd(8'hA4, 8'h44, "R5 duty hi");   rd(8'hA5, 8'hFC, "R5 control");
    rd(8'hA8, 8'h3C, "R5 pin select");
    rd(8'hA6, 8'h00, "R6 unused");    rd(8'hA7, 8'h00, "R6 unused");
    rd(8'h9F, 8'h00, "R6 unused");    rd(8'h00, 8'h00, "R6 unused");
    rd(8'hFF, 8'h00, "R6 unused");
    @(negedge clk_i);

    // R10 pin select: only 2'b10 in bits [7:6] routes PWM
    wr(8'hA5, 8'h01);
    for (int m = 0; m < 4; m++) begin
      wr(8'hA8, {2'(m), 6'b111111});
      for (int g = 0; g < 2; g++) begin
        gpio_i = g[0]; #1;
        chk({15'b0, pad_o}, (m == 2) ? 16'd1 : {15'b0, g[0]}, "R10 pin select");
      end
    end
    gpio_i = 1'b0;
    wr(8'hA8, 8'h80);

    // R1 R2 R3 R4 R9 sweep
    for (int p = 0; p < 4; p++)
      for (int si = 0; si < 5; si++)
        for (int d = 0; d <= scales[si] + 1; d++)
          for (int iv = 0; iv < 2; iv++) begin
            string tg;
            if (d == 0 || d >= scales[si]) tg = "R3 constant level";
            else if (p == 0)               tg = "R4 zero prescaler";
            else if (iv == 1)              tg = "R9 inverted";
            else                           tg = "R1,R2 period and duty";
            run_cfg(p, scales[si], d, iv[0], 2 * ((p == 0 ? 1 : p) * scales[si] + 1) + 2, tg);
          end

    // 16-bit byte order
    run_cfg(2, 16'h0100, 16'h0080, 1'b0, 2 * 513 + 2, "R5 16-bit pair order");

    // R7 shadow: duty changed mid-period
    wr(8'hA5, 8'h00); wr(8'hA0, 8'd1); wr(8'hA1, 8'd4); wr(8'hA2, 8'd0);
    wr(8'hA3, 8'd1); wr(8'hA4, 8'd0); wr(8'hA5, 8'h02);
    for (int t = 0; t < 15; t++) begin
      chk({15'b0, pad_o}, {15'b0, exp_out(1, 4, (t < 5) ? 1 : 3, 1'b0, t)}, "R7 shadowed duty");
      if (t == 2) begin we_i = 1'b1; addr_i = 8'hA3; wdata_i = 8'd3; end
      else        we_i = 1'b0;
      @(negedge clk_i);
    end
    we_i = 1'b0;

    // R8 disable mid-period
    wr(8'hA5, 8'h01);
    chk({15'b0, pad_o}, 16'd1, "R8 disable mid-period");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule